// File: doc/BRIEF.md
# Video Pixel Grab Capture Unit

This block takes one sample of a video decoder's internal data paths and holds it for the host to read. It captures luma, mixed sync and the demodulated U and V values at a chosen pixel position. The grab pulse can come from three places. It can be the pixel-position match strobe alone, which grabs on every line. It can be the AND of the pixel, line and field strobes, which grabs once per four-field or eight-field sequence. Or it can come from an external pin.

The pulse passes through a delay line of `ALIGN_DLY` pixel clocks, so that every component refers to the same pixel relative to line sync. Luma and mixed sync share one 10-bit bus, and U and V share a second 10-bit bus. Both buses alternate at the pixel clock. A `bus_phase` input marks which value each bus carries. The block latches one phase 0 beat and the phase 1 beat that follows it, then writes all four 10-bit values into five 8-bit registers in a single update. It sets a done flag at that update, and the host clears the flag with an acknowledge.

Top module: `pixgrab_capture`

## Requirements
- R1: After reset, all five grab registers are 0 and `grab_done` is 0.
- R2: With `sel_ext` = 1, the grab pulse is `ext_grab`. The internal strobes and the mode bits are then ignored.
- R3: With `sel_ext` = 0 and `every_line` = 1, `pix_hit` alone is the grab pulse.
- R4: With `sel_ext` = 0, `every_line` = 0 and `seq_en` = 1, the grab pulse is `pix_hit & line_hit & field_hit`. If any one of the three strobes is low, nothing is captured.
- R5: With `sel_ext`, `every_line` and `seq_en` all 0, no capture happens.
- R6: A grab pulse sampled at clock edge n is acted on at edge n+`ALIGN_DLY`. The first beat is latched at that edge if `bus_phase` is 0 there, otherwise at the next edge.
- R7: The first beat latches Y from `ym_bus` and U from `uv_bus` with `bus_phase` = 0. The beat at the next edge latches MS from `ym_bus` and V from `uv_bus` with `bus_phase` = 1. All four values come from the same pixel.
- R8: The registers are updated together at the second beat:
  - `grab_r0` = Y[9:2]
  - `grab_r1` = MS[9:2]
  - `grab_r2` = U[9:2]
  - `grab_r3` = V[9:2]
  - `grab_r4` = {Y[1:0], MS[1:0], U[1:0], V[1:0]}, with Y in bits 7:6 and V in bits 1:0.
- R9: `grab_done` goes to 1 at the edge where the registers are written. The registers do not change at any other edge.
- R10: `host_ack` = 1 at an edge clears `grab_done`, unless a register update happens at the same edge; in that case `grab_done` stays 1.
- R11: A later grab overwrites all five registers with the new pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_hit | input | 1 | Pixel position match strobe |
| line_hit | input | 1 | Line match strobe |
| field_hit | input | 1 | Field-sequence match strobe |
| ext_grab | input | 1 | External grab pin |
| every_line | input | 1 | Grab on every line |
| seq_en | input | 1 | Grab once per field sequence |
| sel_ext | input | 1 | Take the grab pulse from `ext_grab` |
| bus_phase | input | 1 | 0: buses carry Y/U; 1: buses carry MS/V |
| ym_bus | input | 10 | Multiplexed luma / mixed sync bus |
| uv_bus | input | 10 | Multiplexed U / V bus |
| host_ack | input | 1 | Clears the done flag |
| grab_r0 | output | 8 | Y bits 9:2 |
| grab_r1 | output | 8 | MS bits 9:2 |
| grab_r2 | output | 8 | U bits 9:2 |
| grab_r3 | output | 8 | V bits 9:2 |
| grab_r4 | output | 8 | Packed LSB pairs Y, MS, U, V |
| grab_done | output | 1 | Capture complete |

## Verification
The bench drives each bus with a different function of the pixel index in each phase. Any beat taken from the wrong phase or the wrong pixel therefore shows up as a register mismatch, and so does any swap in the LSB packing. Grab pulses are issued at both even and odd edges, which separates the case where the capture starts at once from the case where it waits one beat for phase 0. Each source mode is tried with its own strobe and with a strobe it must ignore, including a sequence grab with one strobe missing. A second grab checks that the registers are overwritten.

// File: rtl/pixgrab_capture.sv
module pixgrab_capture #(
  parameter int ALIGN_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_hit,
  input  logic       line_hit,
  input  logic       field_hit,
  input  logic       ext_grab,
  input  logic       every_line,
  input  logic       seq_en,
  input  logic       sel_ext,
  input  logic       bus_phase,
  input  logic [9:0] ym_bus,
  input  logic [9:0] uv_bus,
  input  logic       host_ack,
  output logic [7:0] grab_r0,
  output logic [7:0] grab_r1,
  output logic [7:0] grab_r2,
  output logic [7:0] grab_r3,
  output logic [7:0] grab_r4,
  output logic       grab_done
);
  localparam int DL = (ALIGN_DLY < 2) ? 2 : ALIGN_DLY;

  logic          pulse, trig, want, beat_a, beat_b, pend;
  logic [DL-1:0] dly;
  logic [9:0]    y_hold, u_hold;

  assign pulse = sel_ext    ? ext_grab :
                 every_line ? pix_hit  :
                 seq_en     ? (pix_hit & line_hit & field_hit) : 1'b0;

  assign trig   = dly[DL-1];
  assign want   = pend | trig;
  assign beat_a = want & ~bus_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly    <= '0;
      pend   <= 1'b0;
      beat_b <= 1'b0;
      y_hold <= '0;
      u_hold <= '0;
    end else begin
      dly    <= {dly[DL-2:0], pulse};
      pend   <= want & bus_phase;
      beat_b <= beat_a;
      if (beat_a) begin
        y_hold <= ym_bus;
        u_hold <= uv_bus;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grab_r0   <= '0;
      grab_r1   <= '0;
      grab_r2   <= '0;
      grab_r3   <= '0;
      grab_r4   <= '0;
      grab_done <= 1'b0;
    end else if (beat_b) begin
      grab_r0   <= y_hold[9:2];
      grab_r1   <= ym_bus[9:2];
      grab_r2   <= u_hold[9:2];
      grab_r3   <= uv_bus[9:2];
      grab_r4   <= {y_hold[1:0], ym_bus[1:0], u_hold[1:0], uv_bus[1:0]};
      grab_done <= 1'b1;
    end else if (host_ack) begin
      grab_done <= 1'b0;
    end
  end
endmodule

module pixgrab_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ack,
  input logic       grab_done,
  input logic       bus_phase,
  input logic       beat_b,
  input logic [7:0] grab_r0,
  input logic [7:0] grab_r4
);
  p_commit_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_b |=> grab_done);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !beat_b) |=> !grab_done);

  p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_b |=> ($stable(grab_r0) && $stable(grab_r4)));

  p_done_from_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grab_done) |-> $past(beat_b));

  p_second_beat_phase1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_b |-> bus_phase);
endmodule

bind pixgrab_capture pixgrab_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .grab_done(grab_done),
  .bus_phase(bus_phase), .beat_b(beat_b), .grab_r0(grab_r0), .grab_r4(grab_r4)
);

// File: tb/pixgrab_capture_tb.sv
module pixgrab_capture_tb;
  localparam int DLY = 4;

  logic clk = 0, rst_n = 0;
  logic pix_hit = 0, line_hit = 0, field_hit = 0, ext_grab = 0;
  logic every_line = 0, seq_en = 0, sel_ext = 0, bus_phase = 0, host_ack = 0;
  logic [9:0] ym_bus = 0, uv_bus = 0;
  logic [7:0] grab_r0, grab_r1, grab_r2, grab_r3, grab_r4;
  logic grab_done;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pixgrab_capture #(.ALIGN_DLY(DLY)) u_dut (.*);

  function automatic logic [9:0] fy (int p);  return 10'((p * 37 + 5));    endfunction
  function automatic logic [9:0] fms(int p);  return 10'((p * 53 + 900));  endfunction
  function automatic logic [9:0] fu (int p);  return 10'((p * 11 + 300));  endfunction
  function automatic logic [9:0] fv (int p);  return 10'((p * 29 + 77));   endfunction

  function automatic logic [39:0] pack(int p);
    logic [9:0] y, m, u, v;
    y = fy(p); m = fms(p); u = fu(p); v = fv(p);
    return {y[9:2], m[9:2], u[9:2], v[9:2], y[1:0], m[1:0], u[1:0], v[1:0]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // bus for the upcoming edge number cyc: phase = cyc[0], pixel = cyc/2
  always @(negedge clk) begin
    bus_phase <= cyc[0];
    ym_bus    <= cyc[0] ? fms(cyc / 2) : fy(cyc / 2);
    uv_bus    <= cyc[0] ? fv(cyc / 2)  : fu(cyc / 2);
  end

  task automatic check(input bit ok, input string msg, input logic [39:0] act, input logic [39:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", msg, act, expv);
    end
  endtask

  // monitor: scoreboard pop on every rising done flag, then acknowledge
  logic prev_done = 0;
  always @(negedge clk) begin
    if (rst_n && grab_done && !prev_done) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 R2 R4 unexpected capture", {grab_r0, grab_r1, grab_r2, grab_r3, grab_r4}, 40'h0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({grab_r0, grab_r1, grab_r2, grab_r3, grab_r4} == e,
              {t, " R6 R7 R8 R11 captured pixel"},
              {grab_r0, grab_r1, grab_r2, grab_r3, grab_r4}, e);
      end
      host_ack <= 1;
    end else begin
      host_ack <= 0;
    end
    prev_done <= grab_done;
  end

  task automatic grab(input logic e, input logic p, input logic l, input logic f,
                      input bit expect_cap, input string tag);
    @(negedge clk);
    ext_grab = e; pix_hit = p; line_hit = l; field_hit = f;
    if (expect_cap) begin
      int m;
      m = cyc + DLY;
      if (m % 2) m++;
      exp_q.push_back(pack(m / 2));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ext_grab = 0; pix_hit = 0; line_hit = 0; field_hit = 0;
    repeat (14) @(negedge clk);
    if (expect_cap)
      check(exp_q.size() == 0, {tag, " capture occurred"}, 40'(exp_q.size()), 40'h0);
    else
      check(grab_done == 0, {tag, " no capture"}, {39'h0, grab_done}, 40'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({grab_r0, grab_r1, grab_r2, grab_r3, grab_r4, 7'h0, grab_done} == 48'h0,
          "R1 reset state", {grab_r0, grab_r1, grab_r2, grab_r3, grab_r4}, 40'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5: no source enabled
    grab(1, 1, 1, 1, 0, "R5");
    // R3: every-line mode, both edge parities
    every_line = 1;
    grab(0, 1, 0, 0, 1, "R3 even/odd");
    @(negedge clk);
    grab(0, 1, 0, 0, 1, "R3 other parity");
    grab(1, 0, 1, 1, 0, "R3 ignores ext");
    // R4: sequence mode
    every_line = 0; seq_en = 1;
    grab(0, 1, 1, 0, 0, "R4 field missing");
    grab(0, 1, 0, 1, 0, "R4 line missing");
    grab(0, 1, 1, 1, 1, "R4 all strobes");
    @(negedge clk);
    grab(0, 1, 1, 1, 1, "R4 other parity");
    // R2: external source
    sel_ext = 1; every_line = 1;
    grab(0, 1, 1, 1, 0, "R2 internal ignored");
    grab(1, 0, 0, 0, 1, "R2 ext pin");
    @(negedge clk);
    grab(1, 0, 0, 0, 1, "R2 R11 overwrite");
    // R10: acknowledge cleared the flag
    check(grab_done == 0, "R10 ack clears done", {39'h0, grab_done}, 40'h0);
    // R9: registers hold with no capture
    sel_ext = 0; every_line = 0; seq_en = 0;
    begin
      logic [39:0] snap;
      snap = {grab_r0, grab_r1, grab_r2, grab_r3, grab_r4};
      repeat (10) @(negedge clk);
      check({grab_r0, grab_r1, grab_r2, grab_r3, grab_r4} == snap, "R9 registers hold",
            {grab_r0, grab_r1, grab_r2, grab_r3, grab_r4}, snap);
    end
    summary();
  end
endmodule